// File: doc/BRIEF.md
# Write-Protected Configuration Register

This block is one configuration register inside a serial memory device. It sits behind a byte-level two-wire bus front end. That front end turns line activity into start and stop events and received bytes. This block decides whether each byte is acknowledged. It keeps two volatile enable latches and five persistent configuration bits: a two-bit watchdog period, a two-bit power-up select and a block-protect flag.

Software unlocks the register in three bus writes:
1. A write with only the write-enable bit set.
2. A write with both enable bits set.
3. The data write itself.

The new configuration is taken into the persistent copy only when the stop event ends the data write. The register can be read at any time with a random read, which returns one byte. The persistent copy is never touched by reset. It models storage that keeps its value across power loss.

Top module: `ctl_reg_unit`

## Requirements
- R1: After reset, `wel_o`, `rwel_o`, `ack_o`, `commit_o` and `rd_valid_o` are 0. The configuration bits keep the value they held before reset.
- R2: A slave byte is acknowledged only when bits 7:4 equal 1011. Any other slave byte is not acknowledged, and the rest of that transfer is ignored.
- R3: Bit 1 of the slave byte is address bit 8 and the next byte is address bits 7:0. Only the address 1FFh is acknowledged. A write aimed at any other address changes nothing.
- R4: The register image is {pup1, wd1, wd0, bp, 0, rwel, wel, pup0}, listed from bit 7 down to bit 0.
- R5: A committed write whose data bits 2:1 are 01 sets the write-enable latch. A committed write with bits 2:1 equal to 11 sets the register-write latch, but only when the write-enable latch is already set.
- R6: When both latches are set, the stop after a data write stores data bits 7, 6:5, 4 and 0 into pup1, wd, bp and pup0. That same stop clears the register-write latch and leaves the write-enable latch set. `commit_o` pulses high for exactly one cycle, in the cycle after the stop.
- R7: A data write made while either latch is clear is still acknowledged. It leaves the configuration unchanged and does not pulse `commit_o`.
- R8: Only the first data byte of a write is acknowledged. Later bytes are not acknowledged and are discarded.
- R9: Only a stop commits a write. A repeated start that follows the data byte discards it.
- R10: A random read needs three steps: a write of the address 1FFh, then a repeated start, then a slave byte with bit 0 = 1. The read returns the register image on the first `rd_req_i` only. A read slave byte sent without the address being set first is not acknowledged.
- R11: Bit 3 of the read data is always 0, even after a data byte with bit 3 set has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated-start event |
| stop_i | input | 1 | Stop event |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Master requests a read byte |
| ack_o | output | 1 | Acknowledge decision for the last byte |
| rd_valid_o | output | 1 | Read byte presented on rd_data_o |
| rd_data_o | output | 8 | Read byte |
| wd_o | output | 2 | Watchdog period field |
| pup_o | output | 2 | Power-up select field |
| bp_o | output | 1 | Block-protect field |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write latch |
| commit_o | output | 1 | One-cycle strobe when the persistent copy is written |

## Verification
The same data byte is written several ways: with no latch armed, with only the write-enable latch armed, and fully armed. This shows that the gating and not the data decides whether a commit happens. Wrong preambles and wrong addresses, using both address bit 8 and the low address byte, show that decoding is exact. Extra trailing bytes and a repeated start before stop separate the "first byte only" rule from the "stop only" rule. A reset placed after a commit shows that the volatile latches are cleared while the persistent fields are kept. A written bit 3 shows that this bit always reads as 0.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_DATA, ST_EXTRA, ST_READ
  } seq_state_e;

  typedef struct packed {
    logic       pup1;
    logic [1:0] wd;
    logic       bp;
    logic       pup0;
  } cfg_t;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 9;
  localparam int unsigned WEL_BIT   = 1;
  localparam int unsigned RWEL_BIT  = 2;
endpackage

// File: rtl/ctl_reg_seq.sv
module ctl_reg_seq
  import ctl_reg_pkg::*;
#(
  parameter logic [3:0]        DEV_CODE = 4'b1011,
  parameter logic [ADDR_W-1:0] REG_ADDR = 9'h1FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              rd_req_i,
  input  logic [BYTE_W-1:0] image_i,
  output logic              ack_o,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              wr_go_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  seq_state_e        state_q;
  logic              a8_q, ptr_hit_q, data_got_q, rd_done_q;
  logic [BYTE_W-1:0] data_q;

  assign wr_go_o   = stop_i && data_got_q;
  assign wr_data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      a8_q       <= 1'b0;
      ptr_hit_q  <= 1'b0;
      data_got_q <= 1'b0;
      rd_done_q  <= 1'b0;
      data_q     <= '0;
      ack_o      <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (stop_i) begin
        state_q    <= ST_IDLE;
        ptr_hit_q  <= 1'b0;
        data_got_q <= 1'b0;
      end else if (start_i) begin
        state_q    <= ST_DEV;
        data_got_q <= 1'b0;  // pending data only commits on stop
        rd_done_q  <= 1'b0;
      end else if (byte_valid_i) begin
        unique case (state_q)
          ST_DEV: begin
            if (byte_i[7:4] != DEV_CODE) begin
              ack_o   <= 1'b0;
              state_q <= ST_IDLE;
            end else if (!byte_i[0]) begin
              ack_o   <= 1'b1;
              a8_q    <= byte_i[1];
              state_q <= ST_ADDR;
            end else begin
              ack_o   <= ptr_hit_q;
              state_q <= ptr_hit_q ? ST_READ : ST_IDLE;
            end
          end
          ST_ADDR: begin
            if ({a8_q, byte_i} == REG_ADDR) begin
              ack_o     <= 1'b1;
              ptr_hit_q <= 1'b1;
              state_q   <= ST_DATA;
            end else begin
              ack_o     <= 1'b0;
              ptr_hit_q <= 1'b0;
              state_q   <= ST_IDLE;
            end
          end
          ST_DATA: begin
            ack_o      <= 1'b1;
            data_q     <= byte_i;
            data_got_q <= 1'b1;
            state_q    <= ST_EXTRA;
          end
          ST_EXTRA: ack_o <= 1'b0;
          default: ;
        endcase
      end
      if (rd_req_i && state_q == ST_READ && !rd_done_q) begin
        rd_valid_o <= 1'b1;
        rd_data_o  <= image_i;
        rd_done_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter cfg_t CFG_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_go_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic              wel_o,
  output logic              rwel_o,
  output logic              commit_o,
  output logic [BYTE_W-1:0] image_o
);
  cfg_t nv_q = CFG_INIT;  // persistent copy: no reset
  logic wel_q, rwel_q, armed;

  assign armed = wel_q && rwel_q;

  always_ff @(posedge clk_i) begin
    if (wr_go_i && armed) begin
      nv_q.pup1 <= wr_data_i[7];
      nv_q.wd   <= wr_data_i[6:5];
      nv_q.bp   <= wr_data_i[4];
      nv_q.pup0 <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q    <= 1'b0;
      rwel_q   <= 1'b0;
      commit_o <= 1'b0;
    end else begin
      commit_o <= wr_go_i && armed;
      if (wr_go_i) begin
        if (armed) rwel_q <= 1'b0;
        else if (wr_data_i[RWEL_BIT:WEL_BIT] == 2'b01) wel_q <= 1'b1;
        else if (wr_data_i[RWEL_BIT:WEL_BIT] == 2'b11 && wel_q) rwel_q <= 1'b1;
      end
    end
  end

  assign cfg_o    = nv_q;
  assign wel_o    = wel_q;
  assign rwel_o   = rwel_q;
  assign image_o  = {nv_q.pup1, nv_q.wd, nv_q.bp, 1'b0, rwel_q, wel_q, nv_q.pup0};
endmodule

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit
  import ctl_reg_pkg::*;
#(
  parameter logic [3:0]        DEV_CODE = 4'b1011,
  parameter logic [ADDR_W-1:0] REG_ADDR = 9'h1FF,
  parameter logic [4:0]        CFG_INIT = 5'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       rd_req_i,
  output logic       ack_o,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic [1:0] wd_o,
  output logic [1:0] pup_o,
  output logic       bp_o,
  output logic       wel_o,
  output logic       rwel_o,
  output logic       commit_o
);
  logic              wr_go;
  logic [BYTE_W-1:0] wr_data, image;
  cfg_t              cfg;

  ctl_reg_seq #(.DEV_CODE(DEV_CODE), .REG_ADDR(REG_ADDR)) u_seq (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_valid_i, .byte_i, .rd_req_i,
    .image_i(image), .ack_o, .rd_valid_o, .rd_data_o,
    .wr_go_o(wr_go), .wr_data_o(wr_data)
  );

  ctl_reg_bank #(.CFG_INIT(cfg_t'(CFG_INIT))) u_bank (
    .clk_i, .rst_ni, .wr_go_i(wr_go), .wr_data_i(wr_data),
    .cfg_o(cfg), .wel_o, .rwel_o, .commit_o, .image_o(image)
  );

  assign wd_o  = cfg.wd;
  assign pup_o = {cfg.pup1, cfg.pup0};
  assign bp_o  = cfg.bp;
endmodule

// File: rtl/ctl_reg_unit_chk.sv
module ctl_reg_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic [1:0] wd_o,
  input logic [1:0] pup_o,
  input logic       bp_o,
  input logic       wel_o,
  input logic       rwel_o,
  input logic       commit_o
);
  a_r5_rwel_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_o |-> wel_o);
  a_r6_commit_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  a_r6_commit_clears_rwel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (!rwel_o && wel_o));
  a_r6_cfg_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_o |-> $stable({wd_o, pup_o, bp_o}));
  a_r10_single_read_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  a_r11_bit3_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !rd_data_o[3]);
  a_r4_read_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> rd_data_o == {pup_o[1], wd_o, bp_o, 1'b0, rwel_o, wel_o, pup_o[0]});
endmodule

bind ctl_reg_unit ctl_reg_unit_chk u_chk (.*);

// File: tb/tb_ctl_reg_unit.sv
module tb_ctl_reg_unit;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, byte_valid_i = 0, rd_req_i = 0;
  logic [7:0] byte_i = '0;
  logic ack_o, rd_valid_o, bp_o, wel_o, rwel_o, commit_o;
  logic [7:0] rd_data_o;
  logic [1:0] wd_o, pup_o;
  int checks = 0, errors = 0;

  localparam logic [7:0] SLV_WR = 8'hB2, SLV_RD = 8'hB3;

  ctl_reg_unit dut (.clk_i(clk), .*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ev_start();
    start_i = 1; @(negedge clk); start_i = 0;
  endtask

  task automatic ev_stop(output logic cm);
    stop_i = 1; @(negedge clk); stop_i = 0; cm = commit_o;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    byte_i = b; byte_valid_i = 1; @(negedge clk); byte_valid_i = 0; a = ack_o;
  endtask

  // full write: returns acks of the three bytes and commit
  task automatic write_reg(input logic [7:0] d, output logic [2:0] acks, output logic cm);
    logic a;
    ev_start();
    send(SLV_WR, a); acks[2] = a;
    send(8'hFF, a);  acks[1] = a;
    send(d, a);      acks[0] = a;
    ev_stop(cm);
  endtask

  task automatic read_reg(output logic [7:0] d, output logic v2);
    logic a;
    ev_start(); send(SLV_WR, a); send(8'hFF, a);
    ev_start(); send(SLV_RD, a);
    chk("R10 read slave ack", a, 1);
    rd_req_i = 1; @(negedge clk); rd_req_i = 0;
    chk("R10 first read valid", rd_valid_o, 1);
    d = rd_data_o;
    rd_req_i = 1; @(negedge clk); rd_req_i = 0;
    v2 = rd_valid_o;
    ev_stop(a);
  endtask

  task automatic t_reset();
    chk("R1 wel", wel_o, 0); chk("R1 rwel", rwel_o, 0);
    chk("R1 ack", ack_o, 0); chk("R1 commit", commit_o, 0);
    chk("R1 rd_valid", rd_valid_o, 0);
  endtask

  task automatic t_bad_decode();
    logic a, cm; logic [7:0] d; logic v2;
    ev_start(); send(8'hA2, a); chk("R2 bad preamble nack", a, 0);
    send(8'hFF, a); chk("R2 rest ignored", a, 0); ev_stop(cm);
    ev_start(); send(SLV_WR, a); send(8'hFE, a); chk("R3 low addr nack", a, 0);
    send(8'h02, a); chk("R3 data ignored", a, 0); ev_stop(cm);
    ev_start(); send(8'hB0, a); send(8'hFF, a); chk("R3 a8=0 nack", a, 0);
    send(8'h02, a); ev_stop(cm);
    chk("R3 no wel", wel_o, 0);
    ev_start(); send(SLV_RD, a); chk("R10 read without pointer nack", a, 0); ev_stop(cm);
    read_reg(d, v2); chk("R4 image after reset", d, 8'h00);
    chk("R10 second byte absent", v2, 0);
  endtask

  task automatic t_unarmed();
    logic [2:0] acks; logic cm; logic [7:0] d; logic v2;
    write_reg(8'h06, acks, cm);
    chk("R5 rwel without wel ignored", rwel_o, 0);
    write_reg(8'hF1, acks, cm);
    chk("R7 acked", acks, 3'b111); chk("R7 no commit", cm, 0);
    read_reg(d, v2); chk("R7 cfg unchanged", d, 8'h00);
  endtask

  task automatic t_arm_and_write();
    logic [2:0] acks; logic cm; logic [7:0] d; logic v2;
    write_reg(8'h02, acks, cm);
    chk("R5 wel set", wel_o, 1); chk("R5 rwel clear", rwel_o, 0);
    read_reg(d, v2); chk("R4 wel in bit1", d, 8'h02);
    write_reg(8'hF9, acks, cm);
    chk("R7 wel only no commit", cm, 0); chk("R7 cfg", {pup_o, wd_o, bp_o}, 5'b0);
    write_reg(8'h06, acks, cm);
    chk("R5 rwel set", rwel_o, 1);
    read_reg(d, v2); chk("R4 both latches", d, 8'h06);
    write_reg(8'hF9, acks, cm);
    chk("R6 commit pulse", cm, 1);
    @(negedge clk); chk("R6 commit one cycle", commit_o, 0);
    chk("R6 rwel cleared", rwel_o, 0); chk("R6 wel kept", wel_o, 1);
    chk("R6 fields", {pup_o, wd_o, bp_o}, 5'b11_11_1);
    read_reg(d, v2); chk("R11 bit3 zero", d, 8'hF3);
  endtask

  task automatic t_extra_bytes();
    logic a, cm; logic [2:0] acks; logic [7:0] d; logic v2;
    write_reg(8'h06, acks, cm);
    ev_start(); send(SLV_WR, a); send(8'hFF, a); send(8'h41, a);
    chk("R8 first data ack", a, 1);
    send(8'hFF, a); chk("R8 extra nack", a, 0);
    ev_stop(cm); chk("R8 commit", cm, 1);
    read_reg(d, v2); chk("R8 first byte stored", d, 8'h43);
  endtask

  task automatic t_restart_discard();
    logic a, cm; logic [2:0] acks; logic [7:0] d; logic v2;
    write_reg(8'h06, acks, cm);
    ev_start(); send(SLV_WR, a); send(8'hFF, a); send(8'h00, a);
    ev_start(); ev_stop(cm);
    chk("R9 no commit", cm, 0);
    read_reg(d, v2); chk("R9 unchanged", d, 8'h47);
  endtask

  task automatic t_reset_keeps();
    logic [7:0] d; logic v2;
    rst_ni = 0; @(negedge clk); rst_ni = 1; @(negedge clk);
    chk("R1 wel cleared", wel_o, 0); chk("R1 rwel cleared", rwel_o, 0);
    chk("R1 cfg kept", {pup_o, wd_o, bp_o}, 5'b01_10_0);
    read_reg(d, v2); chk("R1 image kept", d, 8'h41);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_ni = 1; @(negedge clk);
        t_reset();
        t_bad_decode();
        t_unarmed();
        t_arm_and_write();
        t_extra_bytes();
        t_restart_discard();
        t_reset_keeps();
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule